// File: doc/BRIEF.md
# Byte-Wide Processor Data Section

This block is the data half of a small 8-bit processor. A separate control unit drives its select lines and strobes once per clock cycle. The block holds a bank of 32 byte registers. The first 22 of these can be written, and the last 10 return fixed constants. Two read ports put registers onto an A bus and a B bus. The A-side selector chooses between the memory data register and the A bus and feeds the ALU's first operand. The B bus feeds its second operand. A C-side selector chooses between the ALU result and the packed status bits. That choice becomes the C bus, which can be written back into the bank.

Memory reads use a 16-bit address register and a memory data register. The address register is loaded from both buses in one strobe, with the A bus giving the high byte. A small read sequencer watches the read strobe after each address load. It lets the data register take the external data bus only when the strobe has been high for two cycles in a row. The sequencer has four states:

- `RS_IDLE`: the state after reset.
- `RS_ADDR`: an address has been loaded.
- `RS_STROBE1`: one read strobe has been seen.
- `RS_VALID`: two or more strobes in a row have been seen, and bus data may be captured.

Its transitions are as follows:

- An address load in any state goes to `RS_ADDR`.
- `RS_ADDR` with the strobe goes to `RS_STROBE1`.
- `RS_STROBE1` with the strobe goes to `RS_VALID`.
- `RS_STROBE1` or `RS_VALID` without the strobe returns to `RS_ADDR`.
- `RS_VALID` with the strobe stays in `RS_VALID`.
- Without a load or a strobe, `RS_IDLE` and `RS_ADDR` hold.

Four status flags are kept in separate flip-flops, each with its own update strobe: negative, zero, overflow and carry.

Top module: `byte_datapath`

## Requirements
- R1: After reset all writable registers, the four flags, the address register and the data register read zero.
- R2: Register addresses 22 to 31 read, in address order, 0x00, 0x01, 0x02, 0x03, 0x04, 0x08, 0xFA, 0xFC, 0xFE, 0xFF.
- R3: A write strobe addressed to 22 to 31 leaves the constant unchanged.
- R4: With `load_ck` high, the C bus value is stored at the end of the cycle into the register at `sel_c` (0 to 21). Address 6 is the program counter's high byte and 7 its low byte.
- R5: `mar_ck` loads `mem_addr` with the A bus as bits 15:8 and the B bus as bits 7:0.
- R6: With `mdrmux_sel`=0 and `mdr_ck` high, the data register takes `mem_data` only if `mem_read` is high in this cycle and was also high in the previous cycle, with both after the latest address load. Otherwise the data register holds its value.
- R7: `amux_sel`=0 gives the data register and 1 gives the A bus. `cmux_sel`=0 gives {4'b0000, N, Z, V, C} and 1 gives the ALU result.
- R8: ALU op 0 passes the A operand. Op 1 adds A and B. Op 2 adds A, B and the carry flag. For ops 0 to 2, carry-out is the ninth sum bit (0 for pass), V is signed overflow, N is result bit 7 and Z is set when the result is zero.
- R9: Op 15 outputs the A operand and forms its flags from the operand's low nybble: bit 3 gives N, bit 2 gives Z, bit 1 gives V and bit 0 gives C.
- R10: With `andz`=1, a Z update stores the ALU zero output ANDed with the old Z. With `andz`=0 it stores the ALU zero output directly.
- R11: `flag_ck` bits 3, 2, 1 and 0 update N, Z, V and C respectively. A flag whose bit is low keeps its value.
- R12: With `mdrmux_sel`=1 and `mdr_ck` high, the data register takes the C bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_a | input | 5 | A-bus read address |
| sel_b | input | 5 | B-bus read address |
| sel_c | input | 5 | Write address |
| amux_sel | input | 1 | ALU A operand: 0 data register, 1 A bus |
| cmux_sel | input | 1 | C bus: 0 status nybble, 1 ALU result |
| mdrmux_sel | input | 1 | Data register source: 0 memory bus, 1 C bus |
| alu_op | input | 4 | ALU function code |
| load_ck | input | 1 | Register write strobe |
| mar_ck | input | 1 | Address register load strobe |
| mdr_ck | input | 1 | Data register load strobe |
| mem_read | input | 1 | Memory read strobe |
| flag_ck | input | 4 | Flag update strobes, N Z V C |
| andz | input | 1 | Combine new zero with old Z |
| mem_data | input | 8 | External data bus |
| mem_addr | output | 16 | Memory address register |
| cbus | output | 8 | C bus value |
| flags | output | 4 | N Z V C |

## Verification
A stuck or skipped sequencer state shows up at the data register in the same cycle as the capture strobe. Either stale data survives a correct two-strobe read, or bus data gets in after a single strobe. Either fault is visible on `cbus` through the A-side selector one cycle later. A wrong flag register shows on `flags` one edge after its strobe and on `cbus` through the status selector. A corrupted register or constant shows on `cbus` as soon as it is addressed.

// File: rtl/dp_pkg.sv
package dp_pkg;
    localparam int DATA_W     = 8;
    localparam int REG_N      = 32;
    localparam int SEL_W      = $clog2(REG_N);
    localparam int CONST_BASE = 22;
    localparam int CONST_N    = REG_N - CONST_BASE;
    localparam int OP_W       = 4;
    localparam int FLAG_N     = 4;

    // flag bit positions in the packed nybble
    localparam int FN = 3;
    localparam int FZ = 2;
    localparam int FV = 1;
    localparam int FC = 0;

    typedef enum logic [OP_W-1:0] {
        ALU_PASS  = 4'd0,
        ALU_ADD   = 4'd1,
        ALU_ADDC  = 4'd2,
        ALU_FLAGS = 4'd15
    } alu_op_t;

    typedef enum logic [1:0] {
        RS_IDLE    = 2'd0,
        RS_ADDR    = 2'd1,
        RS_STROBE1 = 2'd2,
        RS_VALID   = 2'd3
    } rd_state_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    function automatic logic [DATA_W-1:0] const_value(input int idx);
        case (idx)
            0:       const_value = 8'h00;
            1:       const_value = 8'h01;
            2:       const_value = 8'h02;
            3:       const_value = 8'h03;
            4:       const_value = 8'h04;
            5:       const_value = 8'h08;
            6:       const_value = 8'hFA;
            7:       const_value = 8'hFC;
            8:       const_value = 8'hFE;
            default: const_value = 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/dp_regbank.sv
module dp_regbank
    import dp_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int N  = REG_N,
    parameter int CB = CONST_BASE,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    input  logic [AW-1:0] wa,
    input  logic          we,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  qa,
    output logic [W-1:0]  qb
);
    logic [W-1:0] cells [CB];

    for (genvar i = 0; i < CB; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cells[i] <= '0;
            else if (we && wa == AW'(i))
                cells[i] <= wd;
        end
    end

    function automatic logic [W-1:0] read_port(input logic [AW-1:0] addr,
                                               input logic [W-1:0] arr [CB]);
        logic [W-1:0] res;
        res = '0;
        if (int'(addr) >= CB) begin
            res = const_value(int'(addr) - CB);
        end else begin
            for (int k = 0; k < CB; k++)
                if (addr == AW'(k)) res = arr[k];
        end
        return res;
    endfunction

    always_comb begin
        qa = read_port(ra, cells);
        qb = read_port(rb, cells);
    end

    // R3
    const_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ra) == CB + 1) |-> (qa == W'(1)));
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int OW = OP_W
) (
    input  logic [OW-1:0] op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic          cin,
    output logic [W-1:0]  r,
    output flags_t        fo
);
    logic [W:0] sum;
    logic       cin_eff;

    always_comb begin
        cin_eff = (op == ALU_ADDC) ? cin : 1'b0;
        sum     = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin_eff};
        r       = a;
        fo      = '0;
        case (op)
            ALU_ADD, ALU_ADDC: begin
                r    = sum[W-1:0];
                fo.c = sum[W];
                fo.v = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
                fo.n = sum[W-1];
                fo.z = (sum[W-1:0] == '0);
            end
            ALU_FLAGS: begin
                r    = a;
                fo.n = a[FN];
                fo.z = a[FZ];
                fo.v = a[FV];
                fo.c = a[FC];
            end
            default: begin
                r    = a;
                fo.n = a[W-1];
                fo.z = (a == '0);
            end
        endcase
    end
endmodule

// File: rtl/dp_rdseq.sv
module dp_rdseq
    import dp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic addr_load,
    input  logic strobe,
    output logic capture_ok
);
    rd_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        if (addr_load) begin
            state_nx = RS_ADDR;
        end else begin
            unique case (state)
                RS_IDLE:    state_nx = RS_IDLE;
                RS_ADDR:    state_nx = strobe ? RS_STROBE1 : RS_ADDR;
                RS_STROBE1: state_nx = strobe ? RS_VALID : RS_ADDR;
                RS_VALID:   state_nx = strobe ? RS_VALID : RS_ADDR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            RS_STROBE1, RS_VALID: capture_ok = strobe;
            default:              capture_ok = 1'b0;
        endcase
    end

    // R6
    strobe_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_ok |-> (strobe && $past(strobe)));

    // R6
    valid_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_VALID) |-> $past(strobe));
endmodule

// File: rtl/byte_datapath.sv
module byte_datapath
    import dp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    sel_a,
    input  logic [SEL_W-1:0]    sel_b,
    input  logic [SEL_W-1:0]    sel_c,
    input  logic                amux_sel,
    input  logic                cmux_sel,
    input  logic                mdrmux_sel,
    input  logic [OP_W-1:0]     alu_op,
    input  logic                load_ck,
    input  logic                mar_ck,
    input  logic                mdr_ck,
    input  logic                mem_read,
    input  logic [FLAG_N-1:0]   flag_ck,
    input  logic                andz,
    input  logic [DATA_W-1:0]   mem_data,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0]   cbus,
    output logic [FLAG_N-1:0]   flags
);
    logic [DATA_W-1:0] abus, bbus, amux_out, alu_r, mdr;
    logic [2*DATA_W-1:0] mar;
    flags_t            st, alu_f;
    logic              capture_ok;

    dp_regbank #(.W(DATA_W), .N(REG_N), .CB(CONST_BASE)) u_bank (
        .clk (clk), .rst_n (rst_n),
        .ra  (sel_a), .rb (sel_b), .wa (sel_c),
        .we  (load_ck), .wd (cbus),
        .qa  (abus), .qb (bbus)
    );

    assign amux_out = amux_sel ? abus : mdr;

    dp_alu #(.W(DATA_W), .OW(OP_W)) u_alu (
        .op (alu_op), .a (amux_out), .b (bbus), .cin (st.c),
        .r  (alu_r),  .fo (alu_f)
    );

    assign cbus = cmux_sel ? alu_r : {{(DATA_W-FLAG_N){1'b0}}, st};

    dp_rdseq u_rdseq (
        .clk (clk), .rst_n (rst_n),
        .addr_load (mar_ck), .strobe (mem_read),
        .capture_ok (capture_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mar <= '0;
        else if (mar_ck) mar <= {abus, bbus};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdr <= '0;
        end else if (mdr_ck) begin
            if (mdrmux_sel)      mdr <= cbus;
            else if (capture_ok) mdr <= mem_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= '0;
        end else begin
            if (flag_ck[FN]) st.n <= alu_f.n;
            if (flag_ck[FZ]) st.z <= andz ? (alu_f.z & st.z) : alu_f.z;
            if (flag_ck[FV]) st.v <= alu_f.v;
            if (flag_ck[FC]) st.c <= alu_f.c;
        end
    end

    assign mem_addr = mar;
    assign flags    = st;

    // R5
    mar_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mar_ck |=> (mem_addr == {$past(abus), $past(bbus)}));

    // R6
    mdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdr_ck && !mdrmux_sel && !capture_ok) |=> $stable(mdr));

    // R10
    andz_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ck[FZ] && andz && !st.z) |=> !st.z);

    // R11
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_ck[FC] |=> $stable(st.c));
endmodule

// File: tb/byte_datapath_bench.sv
module byte_datapath_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  sel_a = '0, sel_b = '0, sel_c = '0;
    logic        amux_sel = 0, cmux_sel = 0, mdrmux_sel = 0;
    logic [3:0]  alu_op = '0;
    logic        load_ck = 0, mar_ck = 0, mdr_ck = 0, mem_read = 0, andz = 0;
    logic [3:0]  flag_ck = '0;
    logic [7:0]  mem_data = '0;
    logic [15:0] mem_addr;
    logic [7:0]  cbus;
    logic [3:0]  flags;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    byte_datapath u_byte_datapath (
        .clk (clk), .rst_n (rst_n), .sel_a (sel_a), .sel_b (sel_b), .sel_c (sel_c),
        .amux_sel (amux_sel), .cmux_sel (cmux_sel), .mdrmux_sel (mdrmux_sel),
        .alu_op (alu_op), .load_ck (load_ck), .mar_ck (mar_ck), .mdr_ck (mdr_ck),
        .mem_read (mem_read), .flag_ck (flag_ck), .andz (andz), .mem_data (mem_data),
        .mem_addr (mem_addr), .cbus (cbus), .flags (flags)
    );

    typedef struct packed {
        logic [4:0] a;
        logic [4:0] b;
        logic [3:0] op;
        logic       cin;
        logic [7:0] res;
        logic [3:0] nzvc;
    } vec_t;

    // operands are constant registers: 22=00 23=01 24=02 25=03 26=04 27=08 28=FA 29=FC 30=FE 31=FF
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{a:5'd31, b:5'd23, op:4'd1,  cin:1'b0, res:8'h00, nzvc:4'b0101},
        '{a:5'd28, b:5'd29, op:4'd1,  cin:1'b0, res:8'hF6, nzvc:4'b1001},
        '{a:5'd27, b:5'd26, op:4'd2,  cin:1'b1, res:8'h0D, nzvc:4'b0000},
        '{a:5'd31, b:5'd22, op:4'd2,  cin:1'b1, res:8'h00, nzvc:4'b0101},
        '{a:5'd30, b:5'd22, op:4'd0,  cin:1'b1, res:8'hFE, nzvc:4'b1000},
        '{a:5'd31, b:5'd22, op:4'd15, cin:1'b0, res:8'hFF, nzvc:4'b1111},
        '{a:5'd28, b:5'd22, op:4'd15, cin:1'b0, res:8'hFA, nzvc:4'b1010},
        '{a:5'd24, b:5'd25, op:4'd1,  cin:1'b1, res:8'h05, nzvc:4'b0000},
        '{a:5'd30, b:5'd23, op:4'd2,  cin:1'b0, res:8'hFF, nzvc:4'b1000},
        '{a:5'd22, b:5'd22, op:4'd0,  cin:1'b0, res:8'h00, nzvc:4'b0100}
    };

    function automatic logic [7:0] exp_const(input int i);
        logic [7:0] t [10] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04,
                               8'h08, 8'hFA, 8'hFC, 8'hFE, 8'hFF};
        return t[i];
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic quiet();
        load_ck = 0; mar_ck = 0; mdr_ck = 0; mem_read = 0; flag_ck = '0;
        andz = 0; mdrmux_sel = 0; amux_sel = 1; cmux_sel = 1; alu_op = 4'd0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        quiet();
    endtask

    task automatic peek(input logic [4:0] r, output logic [7:0] v);
        sel_a = r; amux_sel = 1; cmux_sel = 1; alu_op = 4'd0;
        #1 v = cbus;
    endtask

    task automatic peek_mdr(output logic [7:0] v);
        amux_sel = 0; cmux_sel = 1; alu_op = 4'd0;
        #1 v = cbus;
        amux_sel = 1;
    endtask

    // flags from the low nybble of a constant register
    task automatic set_flags(input logic [4:0] r);
        sel_a = r; amux_sel = 1; alu_op = 4'd15; flag_ck = 4'hF;
        tick();
    endtask

    task automatic mem_fetch(input logic [7:0] val);
        sel_a = 5'd6; sel_b = 5'd7; mar_ck = 1; tick();
        mem_read = 1; tick();
        mem_read = 1; mdr_ck = 1; mdrmux_sel = 0; mem_data = val; tick();
        mem_data = 8'h00;
    endtask

    task automatic put_reg(input logic [4:0] dst, input logic [7:0] val);
        mem_fetch(val);
        amux_sel = 0; alu_op = 4'd0; cmux_sel = 1; sel_c = dst; load_ck = 1; tick();
    endtask

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        quiet();
        #12 rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 flags", 16'(flags), 16'h0);
        chk("R1 mem_addr", mem_addr, 16'h0);
        peek(5'd6, v); chk("R1 reg6", 16'(v), 16'h0);
        peek(5'd21, v); chk("R1 reg21", 16'(v), 16'h0);
        peek_mdr(v); chk("R1 mdr", 16'(v), 16'h0);

        // R2 constants
        for (int i = 0; i < 10; i++) begin
            peek(5'(22 + i), v);
            chk("R2 const", 16'(v), 16'(exp_const(i)));
        end

        // R8 R9 vector table
        for (int i = 0; i < NV; i++) begin
            set_flags(VECS[i].cin ? 5'd23 : 5'd22);
            sel_a = VECS[i].a; sel_b = VECS[i].b; alu_op = VECS[i].op;
            amux_sel = 1; cmux_sel = 1; flag_ck = 4'hF;
            #1 chk((VECS[i].op == 4'd15) ? "R9 result" : "R8 result",
                   16'(cbus), 16'(VECS[i].res));
            tick();
            chk((VECS[i].op == 4'd15) ? "R9 flags" : "R8 flags",
                16'(flags), 16'(VECS[i].nzvc));
        end

        // R7 status nybble through C-side selector (flags 0100 now)
        set_flags(5'd28);
        cmux_sel = 0; #1 chk("R7 status nybble", 16'(cbus), 16'h000A);
        cmux_sel = 1;

        // R3 write to a constant ignored
        sel_a = 5'd31; sel_c = 5'd23; load_ck = 1; tick();
        peek(5'd23, v); chk("R3 const kept", 16'(v), 16'h01);

        // R4 register writes incl. program counter halves
        sel_a = 5'd28; sel_c = 5'd6; load_ck = 1; tick();
        sel_a = 5'd25; sel_c = 5'd7; load_ck = 1; tick();
        peek(5'd6, v); chk("R4 pc hi", 16'(v), 16'hFA);
        peek(5'd7, v); chk("R4 pc lo", 16'(v), 16'h03);
        peek(5'd11, v); chk("R4 neighbour untouched", 16'(v), 16'h00);

        // R5 address register from both buses
        sel_a = 5'd29; sel_b = 5'd24; mar_ck = 1; tick();
        chk("R5 mem_addr", mem_addr, 16'hFC02);

        // R6 broken strobe: no capture
        sel_a = 5'd6; sel_b = 5'd7; mar_ck = 1; tick();
        chk("R5 pc to addr", mem_addr, 16'hFA03);
        mem_read = 1; mem_data = 8'h5A; tick();
        mem_read = 0; mdr_ck = 1; mem_data = 8'h5A; tick();
        peek_mdr(v); chk("R6 no capture without strobe", 16'(v), 16'h00);
        // R6 capture in first strobe cycle refused
        sel_a = 5'd6; sel_b = 5'd7; mar_ck = 1; tick();
        mem_read = 1; mdr_ck = 1; mem_data = 8'h77; tick();
        peek_mdr(v); chk("R6 no capture on first strobe", 16'(v), 16'h00);
        // R6 good two-strobe read
        mem_fetch(8'h5A);
        peek_mdr(v); chk("R6 capture", 16'(v), 16'h5A);

        // R12 data register from C bus
        sel_a = 5'd29; amux_sel = 1; cmux_sel = 1; mdrmux_sel = 1; mdr_ck = 1; tick();
        peek_mdr(v); chk("R12 mdr from cbus", 16'(v), 16'hFC);

        // R4 R8 signed overflow: 0x80 + 0xFF
        put_reg(5'd12, 8'h80);
        peek(5'd12, v); chk("R4 loaded reg12", 16'(v), 16'h80);
        sel_a = 5'd12; sel_b = 5'd31; alu_op = 4'd1; amux_sel = 1; cmux_sel = 1; flag_ck = 4'hF;
        #1 chk("R8 overflow result", 16'(cbus), 16'h7F);
        tick();
        chk("R8 overflow flags", 16'(flags), 16'b0011);

        // R10 and-zero
        set_flags(5'd22);
        sel_a = 5'd22; alu_op = 4'd0; andz = 1; flag_ck = 4'b0100; tick();
        chk("R10 z stays clear", 16'(flags), 16'b0000);
        set_flags(5'd26);
        sel_a = 5'd22; alu_op = 4'd0; andz = 1; flag_ck = 4'b0100; tick();
        chk("R10 z stays set", 16'(flags), 16'b0100);
        sel_a = 5'd31; alu_op = 4'd0; andz = 1; flag_ck = 4'b0100; tick();
        chk("R10 z cleared", 16'(flags), 16'b0000);

        // R11 single flag strobe
        set_flags(5'd31);
        sel_a = 5'd22; alu_op = 4'd0; flag_ck = 4'b0001; tick();
        chk("R11 only carry", 16'(flags), 16'b1110);
        sel_a = 5'd22; alu_op = 4'd0; flag_ck = 4'b0000; tick();
        chk("R11 none", 16'(flags), 16'b1110);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule